// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block is the decision core of an eight-input programmable interrupt controller. It samples eight request lines and holds a pending register, a previous-level register and an in-service register. Each line can be edge-triggered or level-triggered. The block looks for the winning pending, unmasked line under a priority order that rotates from a stored 3-bit offset. It raises its interrupt output only when that winner ranks strictly above every line in service.

A command layer outside the block programs the trigger modes, the mask, the auto-EOI options and the special fully nested option. That layer drives a single acknowledge strobe and an end-of-interrupt strobe with a 2-bit command kind and a 3-bit line index. The pending and in-service registers are brought out so that the same layer can return them on reads. The interrupt output and the line number are combinational functions of the registers and the current configuration inputs.

Top module: `rot_irq_resolver`

## Requirements
- R1: With `trig_level[i]`=0, `pend_o[i]` is set in the cycle after a clock edge that samples `req_in[i]` high when the previous sample was low. A line that falls, or stays high, leaves `pend_o[i]` as it was.
- R2: With `trig_level[i]`=1, `pend_o[i]` follows the value of `req_in[i]` sampled at the previous edge: it is set while the input is high and cleared when it is low.
- R3: Line `(k+offset) mod 8` has rank k, and a smaller rank means higher priority. The candidate is the lowest-rank line of `pend_o & ~mask`, and `irq_num` reports its line number.
- R4: `irq_out` is 1 only when the candidate's rank is strictly less than the rank of the highest-priority in-service line. When `irq_out` is 0, `irq_num` is 7.
- R5: While `sfn_en`=1, in-service bit 2 is left out of the in-service rank used by R4.
- R6: `ack`=1 while `irq_out`=1 clears the pending bit of an edge-triggered winner. If `aeoi_en`=0, it also sets that line's in-service bit. `ack` takes precedence over `eoi`.
- R7: An acknowledge of a level-triggered winner leaves its pending bit set while its input stays high.
- R8: An acknowledge with `aeoi_en`=1 sets no in-service bit. If `rot_aeoi_en`=1 as well, it sets the offset to (winner+1) mod 8.
- R9: `eoi`=1 with `eoi_kind`=0 clears the highest-priority in-service bit. Kind 1 does the same and also sets the offset to (cleared line+1) mod 8.
- R10: `eoi_kind`=2 clears in-service bit `cmd_idx`. `eoi_kind`=3 loads the offset with (`cmd_idx`+1) mod 8.
- R11: `ack` while `irq_out`=0 changes neither the pending nor the in-service register.
- R12: After reset, the pending register, the in-service register and the offset are zero, `irq_out` is 0 and `irq_num` is 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_in | input | 8 | Interrupt request lines |
| trig_level | input | 8 | Per-line trigger mode, 1 = level, 0 = edge |
| mask | input | 8 | Per-line mask, 1 = masked |
| sfn_en | input | 1 | Special fully nested mode on the cascade line (bit 2) |
| aeoi_en | input | 1 | Auto end-of-interrupt on acknowledge |
| rot_aeoi_en | input | 1 | Rotate priority on auto end-of-interrupt |
| ack | input | 1 | Acknowledge strobe |
| eoi | input | 1 | End-of-interrupt command strobe |
| eoi_kind | input | 2 | 0 non-specific, 1 rotating non-specific, 2 specific, 3 set priority |
| cmd_idx | input | 3 | Line index for specific EOI and set priority |
| irq_out | output | 1 | Interrupt request to the processor |
| irq_num | output | 3 | Winning line number, 7 when idle |
| pend_o | output | 8 | Pending register |
| isr_o | output | 8 | In-service register |

## Verification
Some rules are checked by the assertions on every cycle: the edge and level capture of each line, that a raised output always names a pending and unmasked line, that a level line survives its acknowledge, and that an acknowledge with no interrupt leaves the in-service register alone. Other behaviour depends on a chain of commands, and only the bench scenarios can show it. These cover the rotating search across every offset and every request and mask pattern, the strict comparison against lines in service, the cascade exclusion, and how the offset moves after auto-EOI, rotating EOI and set-priority.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    CMD_EOI_NS     = 2'd0,
    CMD_EOI_NS_ROT = 2'd1,
    CMD_EOI_SPEC   = 2'd2,
    CMD_SET_PRIO   = 2'd3
  } eoi_kind_e;
endpackage

// File: rtl/irq_prio_find.sv
// Rotating priority search: rank r looks at line (r + off) mod N.
module irq_prio_find #(
  parameter int N  = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  input  logic [IW-1:0] off,
  output logic          hit,
  output logic [IW:0]   rank,
  output logic [IW-1:0] idx
);
  logic [N-1:0] rot;

  for (genvar r = 0; r < N; r++) begin : g_rot
    assign rot[r] = vec[IW'(r) + off];
  end

  always_comb begin
    hit  = 1'b0;
    rank = (IW+1)'(N);
    idx  = '0;
    for (int r = N - 1; r >= 0; r--) begin
      if (rot[r]) begin
        hit  = 1'b1;
        rank = (IW+1)'(r);
        idx  = IW'(r) + off;
      end
    end
  end
endmodule

// File: rtl/irq_req_latch.sv
// Pending and previous-level registers for edge and level capture.
module irq_req_latch #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_in,
  input  logic [N-1:0] trig_level,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend_q
);
  logic [N-1:0] last_q;
  logic [N-1:0] pend_n;
  logic [N-1:0] last_n;
  logic         upd_en;

  assign upd_en = 1'b1;

  always_comb begin
    last_n = req_in;
    for (int i = 0; i < N; i++) begin
      if (trig_level[i])
        pend_n[i] = req_in[i];
      else
        pend_n[i] = (pend_q[i] & ~clr[i]) | (req_in[i] & ~last_q[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      last_q <= '0;
    end else if (upd_en) begin
      pend_q <= pend_n;
      last_q <= last_n;
    end
  end
endmodule

// File: rtl/rot_irq_resolver.sv
module rot_irq_resolver #(
  parameter int N         = 8,
  parameter int CASC_LINE = 2,
  localparam int IW       = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req_in,
  input  logic [N-1:0]  trig_level,
  input  logic [N-1:0]  mask,
  input  logic          sfn_en,
  input  logic          aeoi_en,
  input  logic          rot_aeoi_en,
  input  logic          ack,
  input  logic          eoi,
  input  logic [1:0]    eoi_kind,
  input  logic [IW-1:0] cmd_idx,
  output logic          irq_out,
  output logic [IW-1:0] irq_num,
  output logic [N-1:0]  pend_o,
  output logic [N-1:0]  isr_o
);
  import irq_pkg::*;

  logic [N-1:0]  isr_q, isr_n;
  logic [IW-1:0] off_q, off_n;
  logic [N-1:0]  clr;
  logic [N-1:0]  svc_vec;
  logic          st_en;

  logic          p_hit, s_hit, e_hit;
  logic [IW:0]   p_rank, s_rank, e_rank;
  logic [IW-1:0] p_idx, s_idx, e_idx;
  eoi_kind_e     kind;

  assign kind = eoi_kind_e'(eoi_kind);

  irq_req_latch #(.N(N)) u_req (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .trig_level(trig_level),
    .clr(clr), .pend_q(pend_o)
  );

  always_comb begin
    svc_vec = isr_q;
    if (sfn_en) svc_vec[CASC_LINE] = 1'b0;
  end

  irq_prio_find #(.N(N)) u_pend (
    .vec(pend_o & ~mask), .off(off_q), .hit(p_hit), .rank(p_rank), .idx(p_idx)
  );
  irq_prio_find #(.N(N)) u_svc (
    .vec(svc_vec), .off(off_q), .hit(s_hit), .rank(s_rank), .idx(s_idx)
  );
  irq_prio_find #(.N(N)) u_eoi (
    .vec(isr_q), .off(off_q), .hit(e_hit), .rank(e_rank), .idx(e_idx)
  );

  assign irq_out = p_hit && (p_rank < s_rank);
  assign irq_num = irq_out ? p_idx : '1;
  assign isr_o   = isr_q;

  always_comb begin
    isr_n = isr_q;
    off_n = off_q;
    clr   = '0;
    if (ack) begin
      if (irq_out) begin
        if (!trig_level[p_idx]) clr[p_idx] = 1'b1;
        if (aeoi_en) begin
          if (rot_aeoi_en) off_n = p_idx + IW'(1);
        end else begin
          isr_n[p_idx] = 1'b1;
        end
      end
    end else if (eoi) begin
      unique case (kind)
        CMD_EOI_NS:     if (e_hit) isr_n[e_idx] = 1'b0;
        CMD_EOI_NS_ROT: if (e_hit) begin
                          isr_n[e_idx] = 1'b0;
                          off_n        = e_idx + IW'(1);
                        end
        CMD_EOI_SPEC:   isr_n[cmd_idx] = 1'b0;
        CMD_SET_PRIO:   off_n = cmd_idx + IW'(1);
        default:        ;
      endcase
    end
  end

  assign st_en = ack | eoi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q <= '0;
      off_q <= '0;
    end else if (st_en) begin
      isr_q <= isr_n;
      off_q <= off_n;
    end
  end

  logic unused_ok;
  assign unused_ok = &{1'b0, s_hit, s_idx, e_rank};
endmodule

// File: rtl/irq_resolver_chk.sv
module irq_resolver_chk #(
  parameter int N  = 8,
  localparam int IW = $clog2(N)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  req_in,
  input logic [N-1:0]  trig_level,
  input logic [N-1:0]  mask,
  input logic          ack,
  input logic          irq_out,
  input logic [IW-1:0] irq_num,
  input logic [N-1:0]  pend_o,
  input logic [N-1:0]  isr_o
);
  for (genvar i = 0; i < N; i++) begin : g_line
    AST_EDGE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      (!trig_level[i] && req_in[i] && !$past(req_in[i])) |=> pend_o[i]); // R1
    AST_LEVEL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_level[i] && !req_in[i]) |=> !pend_o[i]); // R2
    AST_LEVEL_ACK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && irq_out && irq_num == IW'(i) && trig_level[i] && req_in[i]) |=> pend_o[i]); // R7
  end

  AST_WINNER_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (pend_o[irq_num] && !mask[irq_num])); // R4
  AST_IDLE_ACK_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !irq_out) |=> $stable(isr_o)); // R11
endmodule

bind rot_irq_resolver irq_resolver_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_in(req_in), .trig_level(trig_level),
  .mask(mask), .ack(ack), .irq_out(irq_out), .irq_num(irq_num),
  .pend_o(pend_o), .isr_o(isr_o)
);

// File: tb/sim_rot_irq_resolver.sv
`timescale 1ns/1ps
module sim_rot_irq_resolver;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] req_in, trig_level, mask;
  logic       sfn_en, aeoi_en, rot_aeoi_en, ack, eoi;
  logic [1:0] eoi_kind;
  logic [2:0] cmd_idx;
  logic       irq_out;
  logic [2:0] irq_num;
  logic [7:0] pend_o, isr_o;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rot_irq_resolver u0 (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .trig_level(trig_level),
    .mask(mask), .sfn_en(sfn_en), .aeoi_en(aeoi_en), .rot_aeoi_en(rot_aeoi_en),
    .ack(ack), .eoi(eoi), .eoi_kind(eoi_kind), .cmd_idx(cmd_idx),
    .irq_out(irq_out), .irq_num(irq_num), .pend_o(pend_o), .isr_o(isr_o)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_ack();
    ack = 1'b1; tick(); ack = 1'b0;
  endtask

  task automatic do_eoi(logic [1:0] k, logic [2:0] idx);
    eoi = 1'b1; eoi_kind = k; cmd_idx = idx; tick(); eoi = 1'b0;
  endtask

  // expected winner line for an active vector and offset, 8 when none
  function automatic int exp_win(logic [7:0] v, int off);
    for (int r = 0; r < 8; r++)
      if (v[(r + off) % 8]) return (r + off) % 8;
    return 8;
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_in = '0; trig_level = '1; mask = '0;
    sfn_en = 0; aeoi_en = 0; rot_aeoi_en = 0; ack = 0; eoi = 0;
    eoi_kind = 0; cmd_idx = 0;
    tick(); tick();
    rst_n = 1'b1;
    tick();
    // R12 reset state
    chk("R12 irq_out", irq_out, 0);
    chk("R12 irq_num", irq_num, 7);
    chk("R12 pend", pend_o, 0);
    chk("R12 isr", isr_o, 0);

    // R3 / R10 set-priority: every offset, every request pattern (level lines)
    for (int off = 0; off < 8; off++) begin
      do_eoi(2'd3, 3'((off + 7) % 8));
      for (int pat = 0; pat < 256; pat++) begin
        req_in = 8'(pat);
        tick();
        if (pat == 0) begin
          chk("R3 idle irq_out", irq_out, 0);
          chk("R4 idle irq_num", irq_num, 7);
        end else begin
          chk("R3 irq_out", irq_out, 1);
          chk("R3 R10 irq_num", irq_num, exp_win(8'(pat), off));
        end
      end
    end
    // R3 mask sweep at offset 0
    do_eoi(2'd3, 3'd7);
    req_in = 8'hFF;
    for (int m = 0; m < 256; m++) begin
      mask = 8'(m);
      tick();
      if (m == 255) begin
        chk("R3 all masked", irq_out, 0);
      end else begin
        chk("R3 mask irq_out", irq_out, 1);
        chk("R3 mask irq_num", irq_num, exp_win(~8'(m), 0));
      end
    end
    mask = '0; req_in = '0; tick();
    chk("R2 level low clears", pend_o, 0);
    trig_level = '0; tick();

    // R1 edge capture, R6 acknowledge
    req_in = 8'h08; tick();
    chk("R1 rise sets", pend_o, 8'h08);
    chk("R3 edge winner", irq_num, 3);
    req_in = 8'h00; tick();
    chk("R1 fall keeps", pend_o, 8'h08);
    do_ack();
    chk("R6 edge pend cleared", pend_o, 0);
    chk("R6 isr set", isr_o, 8'h08);
    chk("R6 irq_out drops", irq_out, 0);

    // R4 strict comparison with in-service
    req_in = 8'h20; tick();
    chk("R4 lower prio blocked", irq_out, 0);
    chk("R4 blocked irq_num", irq_num, 7);
    req_in = 8'h22; tick();
    chk("R4 higher prio passes", irq_num, 1);
    chk("R4 higher irq_out", irq_out, 1);
    do_ack();
    chk("R6 nested isr", isr_o, 8'h0A);
    chk("R6 pend left", pend_o, 8'h20);
    req_in = 8'h00;

    // R9 non-specific EOI
    do_eoi(2'd0, 3'd0);
    chk("R9 clears highest", isr_o, 8'h08);
    chk("R4 still blocked", irq_out, 0);
    do_eoi(2'd0, 3'd0);
    chk("R9 clears next", isr_o, 8'h00);
    chk("R9 pending released", irq_num, 5);

    // R10 specific EOI
    do_ack();
    chk("R6 isr line5", isr_o, 8'h20);
    do_eoi(2'd2, 3'd5);
    chk("R10 specific clear", isr_o, 8'h00);

    // R11 ack with no interrupt (pending but masked)
    req_in = 8'h01; tick(); req_in = 8'h00;
    mask = 8'h01; tick();
    do_ack();
    chk("R11 pend unchanged", pend_o, 8'h01);
    chk("R11 isr unchanged", isr_o, 8'h00);
    chk("R11 irq_num", irq_num, 7);
    mask = 8'h00; tick();
    chk("R11 unmask", irq_num, 0);
    do_ack();
    do_eoi(2'd2, 3'd0);

    // R7 level ack keeps pending, R2 drop clears
    trig_level = 8'h10; req_in = 8'h10; tick();
    chk("R2 level sets", pend_o, 8'h10);
    do_ack();
    chk("R7 level pend kept", pend_o, 8'h10);
    chk("R7 isr set", isr_o, 8'h10);
    req_in = 8'h00; tick();
    chk("R2 level drop", pend_o, 8'h00);
    do_eoi(2'd2, 3'd4);
    trig_level = 8'h00; tick();

    // R5 special fully nested on line 2
    req_in = 8'h04; tick();
    do_ack();
    chk("R6 isr line2", isr_o, 8'h04);
    req_in = 8'h00; tick();
    req_in = 8'h04; tick();
    chk("R5 blocked without sfn", irq_out, 0);
    sfn_en = 1'b1; #1;
    chk("R5 sfn passes", irq_out, 1);
    chk("R5 sfn irq_num", irq_num, 2);
    sfn_en = 1'b0;
    do_eoi(2'd2, 3'd2);
    do_ack();
    do_eoi(2'd2, 3'd2);
    req_in = 8'h00; tick();
    chk("R5 cleanup", pend_o | isr_o, 0);

    // R8 auto-EOI with rotation
    aeoi_en = 1; rot_aeoi_en = 1;
    req_in = 8'h40; tick();
    do_ack();
    chk("R8 no isr", isr_o, 8'h00);
    chk("R8 pend cleared", pend_o, 8'h00);
    aeoi_en = 0; rot_aeoi_en = 0;
    trig_level = 8'hFF; req_in = 8'h81; tick();
    chk("R8 offset 7 winner", irq_num, 7);
    chk("R8 irq_out", irq_out, 1);

    // R9 rotating non-specific EOI
    do_ack();
    chk("R9 isr line7", isr_o, 8'h80);
    chk("R4 blocked by line7", irq_out, 0);
    do_eoi(2'd1, 3'd0);
    chk("R9 rot clears", isr_o, 8'h00);
    chk("R9 offset 0 winner", irq_num, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule